// File: doc/BRIEF.md
# Early-End Report Queue

This block keeps a short log of transfers that finished before their programmed length because the streaming source marked the end of a packet early. When such an early end is signalled with reporting enabled, the block stores the transfer ID together with the number of bytes that were actually moved. Software reads these records back through a small register window.

To drain the log, software reads the length word, then the ID word, and then the completion word. It repeats this while bit 31 of the completion word stays set. A read of the ID word removes the oldest record. A read of the length word only looks at that record. Every early end, whether reporting is enabled or not, also sets the per-ID completion bit and raises the end-of-transfer pulse. Both happen at the same clock edge that stores the record.

The read port is a single registered data bus. The value for a read issued in one cycle appears on `rd_data` in the next cycle. When there is no read, the bus reads zero.

Top module: `partial_report_queue`

## Requirements
- R1: After reset, `pending` and `eot` are 0, `rd_data` is 0, and reads of the length word (select 0), the ID word (select 1) and the completion word (select 2) all return 0.
- R2: A read with select 0 returns the byte count of the oldest stored record in the low bits, one cycle later. Repeated reads return the same value and remove nothing.
- R3: A read with select 1 returns the ID of the oldest stored record in the low bits, one cycle later. The same read removes that record.
- R4: `pending` is 1 exactly while at least one record is stored. Bit 31 of the completion word read with select 2 shows the same condition.
- R5: An early end with `ev_report` low stores no record.
- R6: Records come out in arrival order. Up to DEPTH (default 8) records are held.
- R7: An early end with reporting enabled that arrives while DEPTH records are held, and no removal happens in the same cycle, is dropped. It sets completion-word bit 30. That bit stays set until the completion word is read, and the read clears it.
- R8: `eot` is 1 in the cycle after each early end, whether reporting is enabled or not, and 0 after a cycle with no early end.
- R9: Completion-word bit N (N < 2^ID_W) is set by an early end with ID N. Reading the completion word clears these bits. When a set and the clearing read fall in the same cycle, the set wins.
- R10: A select-1 read when no record is stored returns 0 and changes nothing.
- R11: When the queue is full, a store and a removal in the same cycle both take effect, and bit 30 is not set.
- R12: `rd_data` is 0 in the cycle after a cycle with no read, or after a read with select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Early-end event strobe |
| ev_report | input | 1 | Reporting enabled for this transfer |
| ev_id | input | ID_W | ID of the early-ended transfer |
| ev_bytes | input | LEN_W | Bytes actually moved |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Word select: 0 length, 1 ID (removes), 2 completion, 3 unused |
| rd_data | output | DATA_W | Registered read data |
| pending | output | 1 | At least one record stored |
| eot | output | 1 | End-of-transfer pulse |

## Verification
A write or read pointer that is off by one shows up on the very next select-0 or select-1 read, as a wrong byte count or a wrong ID. A count that drifts makes `pending` and completion bit 31 disagree with the number of records stored. When the drift reaches full, a record that should be kept is dropped, and bit 30 is set where it should be clear. The bench checks these points on the cycle after each read. It checks the full and empty edges, same-cycle store and removal, and same-cycle set and clear of a completion bit.

// File: rtl/prq_pkg.sv
package prq_pkg;
  typedef enum logic [1:0] {
    SEL_LEN  = 2'd0,
    SEL_ID   = 2'd1,
    SEL_DONE = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/prq_fifo.sv
module prq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 28
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/prq_done_track.sv
module prq_done_track #(
  parameter int ID_W    = 4,
  parameter int NUM_IDS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_valid,
  input  logic [ID_W-1:0]    set_id,
  input  logic               clear,
  output logic [NUM_IDS-1:0] done_bits,
  output logic               eot
);
  logic [NUM_IDS-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    if (set_valid) set_mask = {{(NUM_IDS-1){1'b0}}, 1'b1} << set_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_bits <= '0;
      eot       <= 1'b0;
    end else begin
      done_bits <= (clear ? '0 : done_bits) | set_mask;
      eot       <= set_valid;
    end
  end
endmodule

// File: rtl/partial_report_queue.sv
module partial_report_queue #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic              ev_report,
  input  logic [ID_W-1:0]   ev_id,
  input  logic [LEN_W-1:0]  ev_bytes,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              pending,
  output logic              eot
);
  import prq_pkg::*;

  localparam int NUM_IDS = 1 << ID_W;
  localparam int ENT_W   = ID_W + LEN_W;
  localparam int CNT_W   = $clog2(DEPTH+1);

  logic [ENT_W-1:0]   head;
  logic [CNT_W-1:0]   count;
  logic               full, empty;
  logic               push_req, push_ok, pop_ok, drop, done_rd;
  logic [NUM_IDS-1:0] done_bits;
  logic               ovf_q;
  logic [CNT_W-1:0]   cnt_next;
  logic [DATA_W-1:0]  done_word, rd_next;

  assign push_req = ev_valid && ev_report;
  assign pop_ok   = rd_en && (rd_sel == SEL_ID) && !empty;
  assign push_ok  = push_req && (!full || pop_ok);
  assign drop     = push_req && !push_ok;
  assign done_rd  = rd_en && (rd_sel == SEL_DONE);
  assign cnt_next = count + CNT_W'(push_ok) - CNT_W'(pop_ok);

  prq_fifo #(.DEPTH(DEPTH), .W(ENT_W)) i_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata ({ev_id, ev_bytes}),
    .head  (head),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  prq_done_track #(.ID_W(ID_W), .NUM_IDS(NUM_IDS)) i_done (
    .clk       (clk),
    .rst       (rst),
    .set_valid (ev_valid),
    .set_id    (ev_id),
    .clear     (done_rd),
    .done_bits (done_bits),
    .eot       (eot)
  );

  always_comb begin
    done_word = '0;
    done_word[NUM_IDS-1:0] = done_bits;
    done_word[DATA_W-2]    = ovf_q;
    done_word[DATA_W-1]    = !empty;
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      case (rd_sel)
        SEL_LEN:  if (!empty) rd_next = DATA_W'(head[LEN_W-1:0]);
        SEL_ID:   if (!empty) rd_next = DATA_W'(head[ENT_W-1:LEN_W]);
        SEL_DONE: rd_next = done_word;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      pending <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      rd_data <= rd_next;
      pending <= (cnt_next != '0);
      ovf_q   <= drop | (ovf_q & !done_rd);
    end
  end
endmodule

// File: rtl/prq_checker.sv
module prq_checker #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_valid,
  input logic              ev_report,
  input logic [ID_W-1:0]   ev_id,
  input logic [LEN_W-1:0]  ev_bytes,
  input logic              rd_en,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              pending,
  input logic              eot
);
  // R8
  eot_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> eot);
  // R8
  eot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !eot);
  // R4
  pend_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == 2'd2) |=> (rd_data[DATA_W-1] == $past(pending)));
  // R5
  no_store_chk: assert property (@(posedge clk) disable iff (rst)
    (!pending && !(ev_valid && ev_report)) |=> !pending);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!pending && rd_en && rd_sel == 2'd1) |=> (rd_data == '0));
  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || rd_sel == 2'd3) |=> (rd_data == '0));
endmodule

bind partial_report_queue prq_checker #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ev_valid  (ev_valid),
  .ev_report (ev_report),
  .ev_id     (ev_id),
  .ev_bytes  (ev_bytes),
  .rd_en     (rd_en),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .pending   (pending),
  .eot       (eot)
);

// File: tb/test_partial_report_queue.sv
`timescale 1ns/1ps
module test_partial_report_queue;
  localparam int ID_W = 4, LEN_W = 24, DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ev_valid = 1'b0, ev_report = 1'b0;
  logic [ID_W-1:0]   ev_id = '0;
  logic [LEN_W-1:0]  ev_bytes = '0;
  logic              rd_en = 1'b0;
  logic [1:0]        rd_sel = 2'd0;
  logic [DATA_W-1:0] rd_data;
  logic              pending, eot;

  int n_chk = 0, n_fail = 0;
  logic [31:0] got;

  always #10 clk = ~clk;

  partial_report_queue #(.DEPTH(8), .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_partial_report_queue (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_report(ev_report),
    .ev_id(ev_id), .ev_bytes(ev_bytes), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .pending(pending), .eot(eot)
  );

  // op[63:62]: 0 report event, 1 silent event, 2 read; sel[61:60]; id[59:56]; bytes[55:32]; expected[31:0]
  localparam logic [63:0] VEC [13] = '{
    {2'd0, 2'd0, 4'd3, 24'h000040, 32'h0},
    {2'd0, 2'd0, 4'd7, 24'h000123, 32'h0},
    {2'd1, 2'd0, 4'd9, 24'h000077, 32'h0},
    {2'd2, 2'd0, 4'd0, 24'h0, 32'h00000040},
    {2'd2, 2'd0, 4'd0, 24'h0, 32'h00000040},
    {2'd2, 2'd2, 4'd0, 24'h0, 32'h80000288},
    {2'd2, 2'd1, 4'd0, 24'h0, 32'h00000003},
    {2'd2, 2'd0, 4'd0, 24'h0, 32'h00000123},
    {2'd2, 2'd2, 4'd0, 24'h0, 32'h80000000},
    {2'd2, 2'd1, 4'd0, 24'h0, 32'h00000007},
    {2'd2, 2'd2, 4'd0, 24'h0, 32'h00000000},
    {2'd2, 2'd0, 4'd0, 24'h0, 32'h00000000},
    {2'd2, 2'd1, 4'd0, 24'h0, 32'h00000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [ID_W-1:0] id, input logic [LEN_W-1:0] b, input logic rep);
    @(negedge clk);
    ev_valid = 1'b1; ev_report = rep; ev_id = id; ev_bytes = b;
    @(negedge clk);
    ev_valid = 1'b0; ev_report = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pending", {31'd0, pending}, 32'd0);
    check("R1 eot", {31'd0, eot}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    rd(2'd0, got); check("R1 len", got, 32'd0);
    rd(2'd2, got); check("R1 done", got, 32'd0);

    // R2 R3 R4 R5 R9 R10 table walk
    for (int k = 0; k < 13; k++) begin
      case (VEC[k][63:62])
        2'd0: send(VEC[k][59:56], VEC[k][55:32], 1'b1);
        2'd1: send(VEC[k][59:56], VEC[k][55:32], 1'b0);
        default: begin
          rd(VEC[k][61:60], got);
          check($sformatf("R2/R3/R4/R5/R9/R10 vec%0d", k), got, VEC[k][31:0]);
        end
      endcase
    end
    check("R4 pending empty", {31'd0, pending}, 32'd0);

    // R7 overflow and R6 order
    for (int k = 0; k < 9; k++) send(ID_W'(k), LEN_W'(32'h100 + k), 1'b1);
    check("R4 pending full", {31'd0, pending}, 32'd1);
    rd(2'd2, got); check("R7 overflow set", got, 32'hC00001FF);
    rd(2'd2, got); check("R7 overflow cleared", got, 32'h80000000);
    for (int k = 0; k < 8; k++) begin
      rd(2'd0, got); check("R6 len order", got, 32'h100 + k);
      rd(2'd1, got); check("R6 id order", got, k);
    end
    check("R7 ninth dropped", {31'd0, pending}, 32'd0);

    // R11 store and removal together while full
    for (int k = 0; k < 8; k++) send(ID_W'(k), LEN_W'(32'h200 + k), 1'b1);
    rd(2'd3, got); check("R12 unused select", got, 32'd0);
    @(negedge clk);
    ev_valid = 1'b1; ev_report = 1'b1; ev_id = 4'd9; ev_bytes = 24'h0002AA;
    rd_en = 1'b1; rd_sel = 2'd1;
    @(negedge clk);
    check("R11 popped head", rd_data, 32'd0);
    ev_valid = 1'b0; ev_report = 1'b0; rd_en = 1'b0;
    rd(2'd2, got); check("R11 no overflow", got, 32'h800002FF);
    for (int k = 1; k < 8; k++) begin
      rd(2'd1, got); check("R11 id", got, k);
    end
    rd(2'd0, got); check("R11 last len", got, 32'h2AA);
    rd(2'd1, got); check("R11 last id", got, 32'd9);

    // R9 set wins over clear, R8 eot pulse
    @(negedge clk);
    ev_valid = 1'b1; ev_report = 1'b0; ev_id = 4'd5;
    rd_en = 1'b1; rd_sel = 2'd2;
    @(negedge clk);
    check("R9 read before set", rd_data, 32'd0);
    check("R8 eot high", {31'd0, eot}, 32'd1);
    ev_valid = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    check("R8 eot low", {31'd0, eot}, 32'd0);
    check("R5 silent event", {31'd0, pending}, 32'd0);
    rd(2'd2, got); check("R9 set wins", got, 32'h00000020);
    rd(2'd2, got); check("R9 cleared", got, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule